// File: doc/BRIEF.md
# Content protection receiver register interface

This block is the host-facing register window of a link content-protection receiver. A host bus with word addressing reaches four registers: a control word, a read-only receiver status word, a byte-wide message window and a read-only capability word. In the control word one bit is stored, the content stream type. Two other bits act only as one-shot commands: one clears the sticky protocol-event flag and the other marks the end of a message sequence. No other control bit is kept.

The protocol engine reaches the block through plain strobe and data ports. It pulses an event input to set the sticky event flag, and drives five live status levels that the host reads back. It moves message bytes through two small byte FIFOs. The host pushes bytes toward the engine by writing the message offset repeatedly, and it drains bytes that the engine produced by reading the same offset repeatedly. The host bus uses single-cycle write and read strobes, and read data comes back with a valid flag one cycle after the read strobe.

Top module: `cpr_regif`

## Requirements
- R1: After reset, rvalid, eom_pulse, stream_type, in_valid, out_full and msg_ovf are 0, and reads of the control word (0x40) and the status word (0x41) return 0 while eng_status is 0.
- R2: A write to 0x40 stores wdata bit 0 as the stream type (0 = type 0, 1 = type 1), which drives stream_type and reads back in bit 0. Every other bit of 0x40 reads as 0, including the two command bits 30 and 29.
- R3: A write to 0x40 with bit 30 set clears status bit 18. If evt_irq is high in the same cycle, the flag stays set.
- R4: A one-cycle pulse on evt_irq sets status bit 18 (0x41). The bit stays set until R3 clears it.
- R5: Status bits [4:0] return eng_status[4:0], with bit 4 = link integrity failure, bit 3 = reauthentication request, bit 2 = pairing available, bit 1 = H-prime available and bit 0 = ready. Status bits 31:19 and 17:5 read as 0.
- R6: A write to 0x40 with bit 29 set raises eom_pulse for exactly the one cycle after the write edge.
- R7: A read of 0x43 returns 0x00020002 with bit 0 replaced by cfg_repeater. That is, version 0x02 sits in bits [23:16] and the capable flag in bit 1.
- R8: Each write to 0x42 pushes wdata[7:0] into an inbound FIFO of MSG_DEPTH bytes. The bytes appear on in_data, oldest first, while in_valid is 1. in_pop removes the head.
- R9: A write to 0x42 while the inbound FIFO holds MSG_DEPTH bytes is dropped and sets msg_ovf. msg_ovf stays 1 until a write of R6's end-of-message bit clears it.
- R10: out_push puts out_data into an outbound FIFO of MSG_DEPTH bytes. out_full is 1 when the FIFO holds MSG_DEPTH bytes, and a push while full is dropped. A read of 0x42 returns the oldest byte in bits [7:0] and removes it. A read of 0x42 while the FIFO is empty returns 0.
- R11: rvalid is 1 exactly in the cycle after a read strobe, and rdata carries the addressed word in that cycle. A read of any address other than 0x40 to 0x43 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle host write strobe |
| rd_en | input | 1 | Single-cycle host read strobe |
| addr | input | ADDR_W | Host word address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| stream_type | output | 1 | Stored content stream type |
| eom_pulse | output | 1 | End-of-message command pulse |
| evt_irq | input | 1 | Protocol event pulse, sets the sticky flag |
| eng_status | input | 5 | Live engine status levels |
| cfg_repeater | input | 1 | Repeater configuration for the capability word |
| in_data | output | 8 | Head byte of the inbound FIFO |
| in_valid | output | 1 | Inbound FIFO not empty |
| in_pop | input | 1 | Engine removes the inbound head byte |
| out_push | input | 1 | Engine pushes a byte outbound |
| out_data | input | 8 | Byte pushed by the engine |
| out_full | output | 1 | Outbound FIFO full |
| msg_ovf | output | 1 | Sticky inbound overflow flag |

## Verification
A wrong FIFO pointer or count shows up at the ports as a byte that is out of order, repeated or lost. It appears on in_data, or in rdata at the message offset, within the same fill-and-drain round. A full or empty flag at the wrong depth shows up as a drop one byte early or late, or as a nonzero byte read from an empty window. A sticky flag that loses its state, or loses a set-against-clear collision, shows up on the next status read. A command bit that is wrongly kept shows up on the next read of the control word.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BW = 8;
  localparam int unsigned STS_W = 5;

  localparam int unsigned OFS_CTRL   = 'h40;
  localparam int unsigned OFS_STATUS = 'h41;
  localparam int unsigned OFS_MSG    = 'h42;
  localparam int unsigned OFS_CAP    = 'h43;

  localparam int unsigned CTRL_TYPE_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT  = 30;
  localparam int unsigned CTRL_EOM_BIT  = 29;
  localparam int unsigned STS_EVT_BIT   = 18;

  localparam logic [DW-1:0] CAP_BASE = 32'h0002_0002;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STATUS,
    SEL_MSG,
    SEL_CAP
  } reg_sel_e;
endpackage

// File: rtl/cpr_byte_fifo.sv
module cpr_byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] count, count_nxt;
  logic          push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && not_empty;
  assign head      = mem[rd_ptr];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    count_nxt  = count;
    if (push_ok) wr_ptr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (push_ok && !pop_ok)      count_nxt = count + 1'b1;
    else if (pop_ok && !push_ok) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // R8
  fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9
  full_push_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

  // R10
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty && !push) |=> !not_empty);
endmodule

// File: rtl/cpr_sticky_flag.sv
module cpr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nxt;

  always_comb q_nxt = set | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/cpr_regif.sv
module cpr_regif
  import cpr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MSG_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              stream_type,
  output logic              eom_pulse,
  input  logic              evt_irq,
  input  logic [4:0]        eng_status,
  input  logic              cfg_repeater,
  output logic [7:0]        in_data,
  output logic              in_valid,
  input  logic              in_pop,
  input  logic              out_push,
  input  logic [7:0]        out_data,
  output logic              out_full,
  output logic              msg_ovf
);
  reg_sel_e      sel;
  logic          wr_ctrl, wr_msg, rd_msg;
  logic          clr_evt, eom_cmd;
  logic          evt_q, in_full, out_ne;
  logic [BW-1:0] out_head;
  logic [DW-1:0] rd_word, rdata_nxt;
  logic          type_nxt;
  logic          unused_wdata;

  assign unused_wdata = ^{wdata[31], wdata[28:BW]};

  always_comb begin
    if      (addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFS_MSG))    sel = SEL_MSG;
    else if (addr == ADDR_W'(OFS_CAP))    sel = SEL_CAP;
    else                                  sel = SEL_NONE;
  end

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_msg  = wr_en && (sel == SEL_MSG);
  assign rd_msg  = rd_en && (sel == SEL_MSG);
  assign clr_evt = wr_ctrl && wdata[CTRL_CLR_BIT];
  assign eom_cmd = wr_ctrl && wdata[CTRL_EOM_BIT];

  cpr_sticky_flag u_evt_flag (
    .clk(clk), .rst_n(rst_n), .set(evt_irq), .clr(clr_evt), .q(evt_q)
  );

  cpr_sticky_flag u_ovf_flag (
    .clk(clk), .rst_n(rst_n), .set(wr_msg && in_full), .clr(eom_cmd), .q(msg_ovf)
  );

  cpr_byte_fifo #(.W(BW), .DEPTH(MSG_DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_msg), .push_data(wdata[BW-1:0]),
    .pop(in_pop), .head(in_data), .not_empty(in_valid), .full(in_full)
  );

  cpr_byte_fifo #(.W(BW), .DEPTH(MSG_DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .push(out_push), .push_data(out_data),
    .pop(rd_msg), .head(out_head), .not_empty(out_ne), .full(out_full)
  );

  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_CTRL:   rd_word[CTRL_TYPE_BIT] = stream_type;
      SEL_STATUS: begin
        rd_word[STS_W-1:0]  = eng_status;
        rd_word[STS_EVT_BIT] = evt_q;
      end
      SEL_MSG:    if (out_ne) rd_word[BW-1:0] = out_head;
      SEL_CAP:    rd_word = {CAP_BASE[DW-1:1], cfg_repeater};
      default:    rd_word = '0;
    endcase
  end

  always_comb begin
    rdata_nxt = rd_en ? rd_word : '0;
    type_nxt  = wr_ctrl ? wdata[CTRL_TYPE_BIT] : stream_type;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata       <= '0;
      rvalid      <= 1'b0;
      stream_type <= 1'b0;
      eom_pulse   <= 1'b0;
    end else begin
      rdata       <= rdata_nxt;
      rvalid      <= rd_en;
      stream_type <= type_nxt;
      eom_pulse   <= eom_cmd;
    end
  end

  // R11
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  // R11
  rvalid_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_CTRL) |=> (rdata[31:1] == '0));

  // R10
  empty_msg_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msg && !out_ne) |=> (rdata == '0));

  // R9
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msg && in_full) |=> msg_ovf);

  // R6
  eom_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_pulse && !eom_cmd) |=> !eom_pulse);
endmodule

// File: tb/cpr_regif_tb.sv
`timescale 1ns/1ps
module cpr_regif_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rvalid, stream_type, eom_pulse, evt_irq, cfg_repeater;
  logic [4:0]  eng_status;
  logic [7:0]  in_data, out_data;
  logic        in_valid, in_pop, out_push, out_full, msg_ovf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  cpr_regif #(.ADDR_W(8), .MSG_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .stream_type(stream_type),
    .eom_pulse(eom_pulse), .evt_irq(evt_irq), .eng_status(eng_status),
    .cfg_repeater(cfg_repeater), .in_data(in_data), .in_valid(in_valid),
    .in_pop(in_pop), .out_push(out_push), .out_data(out_data),
    .out_full(out_full), .msg_ovf(msg_ovf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check("R11 rvalid", {31'b0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic eng_push(logic [7:0] b);
    @(negedge clk);
    out_push = 1'b1; out_data = b;
    @(negedge clk);
    out_push = 1'b0;
  endtask

  task automatic eng_pop();
    @(negedge clk);
    in_pop = 1'b1;
    @(negedge clk);
    in_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    evt_irq = 0; eng_status = 0; cfg_repeater = 0;
    in_pop = 0; out_push = 0; out_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rvalid", {31'b0, rvalid}, 0);
    check("R1 eom", {31'b0, eom_pulse}, 0);
    check("R1 type", {31'b0, stream_type}, 0);
    check("R1 in_valid", {31'b0, in_valid}, 0);
    check("R1 out_full", {31'b0, out_full}, 0);
    check("R1 ovf", {31'b0, msg_ovf}, 0);
    bus_rd(8'h40, d); check("R1 ctrl", d, 0);
    bus_rd(8'h41, d); check("R1 status", d, 0);
    @(negedge clk);
    check("R11 rvalid idle", {31'b0, rvalid}, 0);

    // R2 stream type with junk in the other bits (commands avoided)
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = (32'h9E5A_3C71 * (i + 1)) & ~32'h6000_0000;
      w[0] = i[0];
      bus_wr(8'h40, w);
      check("R2 type out", {31'b0, stream_type}, {31'b0, i[0]});
      bus_rd(8'h40, d);
      check("R2 ctrl readback", d, {31'b0, i[0]});
    end
    bus_wr(8'h40, 32'h6000_0001);
    bus_rd(8'h40, d);
    check("R2 command bits read zero", d, 32'd1);

    // R5 status levels, all 32 values
    for (int s = 0; s < 32; s++) begin
      eng_status = 5'(s);
      bus_rd(8'h41, d);
      check("R5 status", d, 32'(s));
    end
    eng_status = 5'h15;

    // R4 event pulse, sticky
    @(negedge clk); evt_irq = 1; @(negedge clk); evt_irq = 0;
    bus_rd(8'h41, d); check("R4 set", d, 32'h0004_0015);
    repeat (5) @(negedge clk);
    bus_rd(8'h41, d); check("R4 sticky", d, 32'h0004_0015);

    // R3 clear, then set wins over clear
    bus_wr(8'h40, 32'h4000_0000);
    bus_rd(8'h41, d); check("R3 clear", d, 32'h0000_0015);
    @(negedge clk);
    evt_irq = 1; wr_en = 1; addr = 8'h40; wdata = 32'h4000_0000;
    @(negedge clk);
    evt_irq = 0; wr_en = 0;
    bus_rd(8'h41, d); check("R3 set wins", d, 32'h0004_0015);
    bus_wr(8'h40, 32'h4000_0000);
    bus_rd(8'h41, d); check("R3 clear again", d, 32'h0000_0015);

    // R6 end-of-message pulse
    bus_wr(8'h40, 32'h2000_0000);
    check("R6 eom high", {31'b0, eom_pulse}, 1);
    @(negedge clk);
    check("R6 eom low", {31'b0, eom_pulse}, 0);
    bus_wr(8'h40, 32'h0000_0000);
    check("R6 no eom", {31'b0, eom_pulse}, 0);

    // R7 capability
    for (int r = 0; r < 2; r++) begin
      cfg_repeater = r[0];
      bus_rd(8'h43, d);
      check("R7 cap", d, 32'h0002_0002 | 32'(r));
    end

    // R11 unmapped addresses read zero
    for (int a = 0; a < 256; a++) begin
      if (a >= 'h40 && a <= 'h43) continue;
      bus_rd(8'(a), d);
      check("R11 unmapped", d, 0);
    end

    // R8 / R9 inbound rounds, filled past depth
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int k = 0; k <= DEPTH; k++)
        bus_wr(8'h42, 32'hABCD_0000 | 32'((rnd * 37 + k * 11) & 8'hFF));
      check("R9 ovf set", {31'b0, msg_ovf}, 1);
      for (int k = 0; k < DEPTH; k++) begin
        check("R8 in_valid", {31'b0, in_valid}, 1);
        check("R8 order", {24'b0, in_data}, 32'((rnd * 37 + k * 11) & 8'hFF));
        eng_pop();
      end
      check("R9 dropped byte absent", {31'b0, in_valid}, 0);
      check("R9 ovf holds", {31'b0, msg_ovf}, 1);
      bus_wr(8'h40, 32'h2000_0000);
      check("R9 ovf cleared", {31'b0, msg_ovf}, 0);
    end

    // R10 outbound rounds, filled past depth
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int k = 0; k <= DEPTH; k++) begin
        b = 8'((rnd * 53 + k * 29 + 1) & 8'hFF);
        eng_push(b);
        if (k == DEPTH - 1) check("R10 full", {31'b0, out_full}, 1);
      end
      for (int k = 0; k < DEPTH; k++) begin
        bus_rd(8'h42, d);
        check("R10 order", d, 32'((rnd * 53 + k * 29 + 1) & 8'hFF));
      end
      check("R10 not full", {31'b0, out_full}, 0);
      bus_rd(8'h42, d);
      check("R10 empty read", d, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule